// File: doc/BRIEF.md
# Dual-Output Clock Post-Divider

This block takes a fast source clock and divides it by a selectable power of two, from 2 to 64. It drives two derived clocks, both with an even 50% duty cycle. Output A runs at the programmed ratio. Output B either repeats output A or runs at half its rate, and its edges always coincide with edges of A. A single internal frame counter spans two periods of A and drives both outputs, so the two outputs cannot drift apart.

The ratio and the B mode may be changed while the outputs run. A new setting is first held in a shadow copy. The divider adopts it only at the end of a frame, the point where both outputs are low. In the cycle that follows, a one-cycle flag reports that the setting was taken. Either output can be stopped on its own. A stopped output completes any high phase it has begun and then stays low. A released output comes back on the next rising edge of its underlying wave, so its first pulse is always a complete high phase.

All inputs are synchronous to the fast clock. The reset is active-low, synchronous, and loads the selection present at the ports directly.

Top module: `dual_clock_postdiv`

## Requirements
- R1: `ratio_sel` values 0 to 5 give a division ratio of 2, 4, 8, 16, 32 and 64 respectively. Output A is high for exactly ratio/2 fast cycles and low for ratio/2 fast cycles.
- R2: `ratio_sel` values 6 and 7 give the same ratio as value 5 (64). Moving between 5, 6 and 7 is not a change of setting.
- R3: With `half_b` = 0, output B equals output A in every cycle. With `half_b` = 1, output B has a period of twice the ratio, is high for exactly one ratio, and every edge of B lands in a cycle where A rises.
- R4: While `rst_n` is low, both outputs and the flag are low. After release, output A stays low for ratio/2 cycles of the selected ratio and then rises.
- R5: The ports are copied to a shadow setting on every cycle. The shadow is adopted when the frame of 2×ratio cycles completes, and from then on both outputs start low. The flag is high for exactly the cycle after an adoption in which the setting differed, and it is never high in any other cycle.
- R6: No high pulse on either output is shorter or longer than its full programmed high phase, including across setting changes and stop/release events.
- R7: While a stop request is held, an output that is high finishes its high phase and then stays low. An output that is already low stays low.
- R8: When a stop request is released, the output stays low until the next rising edge of its underlying wave and never begins high in the middle of a phase.
- R9: Stopping one output has no effect on the other output or on the divider phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_fast | input | 1 | Fast source clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ratio_sel | input | 3 | Ratio code; value k selects 2^(k+1), and values above 5 saturate to 64 |
| half_b | input | 1 | 0: B follows A; 1: B at half the rate of A |
| stop_a | input | 1 | Stop request for output A |
| stop_b | input | 1 | Stop request for output B |
| clk_a | output | 1 | Divided clock A |
| clk_b | output | 1 | Divided clock B |
| cfg_applied | output | 1 | One-cycle pulse when a changed setting is adopted |

## Verification
A frame counter that is off by even one count shows up at the ports within one half-period of A. It appears as a high or low phase of the wrong length, or as B changing in a cycle where A does not rise. A shadow or adopted setting that is wrong shows up at the next frame end, as a missing or extra flag pulse, or as a ratio that does not match the one requested. A fault in a run/stop gate shows up within one phase of the stop or release, as a truncated pulse, an output that never freezes, or a restart in the middle of a phase. The bench compares all three outputs against a behavioural model on every cycle and also measures the length of every high pulse.

// File: rtl/postdiv_pkg.sv
package postdiv_pkg;
   localparam int PD_CODE_W = 3;

   typedef struct packed {
      logic [PD_CODE_W-1:0] code;
      logic                 half;
   } pd_cfg_t;

   function automatic pd_cfg_t pd_normalize(input logic [PD_CODE_W-1:0] sel,
                                            input logic half,
                                            input int unsigned max_log2);
      pd_cfg_t c;
      if (int'(sel) >= int'(max_log2)) c.code = PD_CODE_W'(max_log2 - 1);
      else                             c.code = sel;
      c.half = half;
      return c;
   endfunction
endpackage

// File: rtl/postdiv_cfg_shadow.sv
module postdiv_cfg_shadow
   import postdiv_pkg::*;
#(
   parameter int MAX_LOG2 = 6
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [PD_CODE_W-1:0] sel,
   input  logic                 half,
   input  logic                 frame_end,
   output pd_cfg_t              cfg_cur,
   output logic                 applied
);
   pd_cfg_t req, shadow;

   assign req = pd_normalize(sel, half, MAX_LOG2);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shadow  <= req;
         cfg_cur <= req;
         applied <= 1'b0;
      end else begin
         applied <= frame_end && (shadow != cfg_cur);
         if (frame_end) cfg_cur <= shadow;
         shadow <= req;
      end
   end

   // R2: adopted code never exceeds the largest ratio
   a_r2_code_range: assert property (@(posedge clk) disable iff (!rst_n)
      int'(cfg_cur.code) < MAX_LOG2);

   // R5: adopted setting moves only at a frame end
   a_r5_hold_mid_frame: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_end |=> cfg_cur == $past(cfg_cur));

   // R5: flag is a single-cycle pulse
   a_r5_flag_single: assert property (@(posedge clk) disable iff (!rst_n)
      applied |=> !applied);
endmodule

// File: rtl/postdiv_phase_gen.sv
module postdiv_phase_gen
   import postdiv_pkg::*;
#(
   parameter int MAX_LOG2 = 6
) (
   input  logic    clk,
   input  logic    rst_n,
   input  pd_cfg_t cfg,
   output logic    frame_end,
   output logic    wa_next,
   output logic    wb_next,
   output logic    wa_cur,
   output logic    wb_cur
);
   localparam int CNT_W = MAX_LOG2 + 1;

   logic [CNT_W-1:0] cnt, cnt_n, frame_last;
   logic             tog, tog_n;

   // last count of a frame spanning two periods of A: 2*2^(code+1) - 1
   assign frame_last = (CNT_W'(1) << (cfg.code + 2)) - CNT_W'(1);
   assign frame_end  = (cnt == frame_last);
   assign cnt_n      = frame_end ? '0 : cnt + CNT_W'(1);
   assign wa_next    = |((cnt_n >> cfg.code) & CNT_W'(1));
   assign tog_n      = tog ^ (wa_next & ~wa_cur);

   generate
      if (MAX_LOG2 >= 1) begin : g_b_sel
         assign wb_next = cfg.half ? tog_n : wa_next;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt    <= '0;
         tog    <= 1'b0;
         wa_cur <= 1'b0;
         wb_cur <= 1'b0;
      end else begin
         cnt    <= cnt_n;
         tog    <= tog_n;
         wa_cur <= wa_next;
         wb_cur <= wb_next;
      end
   end

   // checker: length of the current high run of wave A
   logic [CNT_W-1:0] hi_len;
   always_ff @(posedge clk) begin
      if (!rst_n) hi_len <= '0;
      else        hi_len <= wa_next ? hi_len + CNT_W'(1) : '0;
   end

   // R1: every high phase of A lasts exactly ratio/2 cycles
   a_r1_half_period: assert property (@(posedge clk) disable iff (!rst_n)
      (wa_cur && !wa_next) |-> hi_len == (CNT_W'(1) << cfg.code));

   // R5: both waves start low after a frame end
   a_r5_frame_low: assert property (@(posedge clk) disable iff (!rst_n)
      frame_end |=> !wa_cur && !wb_cur);

   // R3: same-rate mode keeps B equal to A
   a_r3_same_rate: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg.half |=> wb_cur == wa_cur);
endmodule

// File: rtl/postdiv_stop_gate.sv
module postdiv_stop_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic stop,
   input  logic w_next,
   input  logic w_cur,
   output logic q
);
   logic run, run_n;

   always_comb begin
      if (run) run_n = !(stop && !w_cur);
      else     run_n = !stop && w_next && !w_cur;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run <= 1'b1;
         q   <= 1'b0;
      end else begin
         run <= run_n;
         q   <= run_n & w_next;
      end
   end

   // R7: a stopped low output stays low
   a_r7_hold_low: assert property (@(posedge clk) disable iff (!rst_n)
      (stop && !q) |=> !q);

   // R6: an output high while its wave stays high is never cut short
   a_r6_no_runt: assert property (@(posedge clk) disable iff (!rst_n)
      (q && w_next) |=> q);

   // R8: no restart in the middle of a high phase
   a_r8_no_mid_start: assert property (@(posedge clk) disable iff (!rst_n)
      (!q && w_cur) |=> !q);
endmodule

// File: rtl/dual_clock_postdiv.sv
module dual_clock_postdiv
   import postdiv_pkg::*;
#(
   parameter int MAX_LOG2 = 6
) (
   input  logic                 clk_fast,
   input  logic                 rst_n,
   input  logic [PD_CODE_W-1:0] ratio_sel,
   input  logic                 half_b,
   input  logic                 stop_a,
   input  logic                 stop_b,
   output logic                 clk_a,
   output logic                 clk_b,
   output logic                 cfg_applied
);
   localparam int N_OUT = 2;

   generate
      if (MAX_LOG2 < 1 || MAX_LOG2 > (1 << PD_CODE_W)) begin : g_bad_param
         $error("MAX_LOG2 out of range for the ratio code width");
      end
   endgenerate

   pd_cfg_t          cfg_cur;
   logic             frame_end, wa_n, wb_n, wa_q, wb_q;
   logic [N_OUT-1:0] stop_v, wn_v, wq_v, q_v;

   postdiv_cfg_shadow #(.MAX_LOG2(MAX_LOG2)) u_shadow (
      .clk(clk_fast), .rst_n(rst_n), .sel(ratio_sel), .half(half_b),
      .frame_end(frame_end), .cfg_cur(cfg_cur), .applied(cfg_applied));

   postdiv_phase_gen #(.MAX_LOG2(MAX_LOG2)) u_phase (
      .clk(clk_fast), .rst_n(rst_n), .cfg(cfg_cur), .frame_end(frame_end),
      .wa_next(wa_n), .wb_next(wb_n), .wa_cur(wa_q), .wb_cur(wb_q));

   assign stop_v = {stop_b, stop_a};
   assign wn_v   = {wb_n, wa_n};
   assign wq_v   = {wb_q, wa_q};

   generate
      for (genvar i = 0; i < N_OUT; i++) begin : g_gate
         postdiv_stop_gate u_gate (
            .clk(clk_fast), .rst_n(rst_n), .stop(stop_v[i]),
            .w_next(wn_v[i]), .w_cur(wq_v[i]), .q(q_v[i]));
      end
   endgenerate

   assign clk_a = q_v[0];
   assign clk_b = q_v[1];

   // R5: adoption happens only where both outputs are low
   a_r5_flag_outputs_low: assert property (@(posedge clk_fast) disable iff (!rst_n)
      cfg_applied |-> !clk_a && !clk_b);

   // R9: while B is stopped and low, A still runs off the shared phase
   a_r9_a_independent: assert property (@(posedge clk_fast) disable iff (!rst_n)
      (!stop_a && clk_a && wa_n) |=> clk_a);
endmodule

// File: tb/dual_clock_postdiv_test.sv
module dual_clock_postdiv_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] sel = 3'd3;
   logic       hb = 1'b0, sa = 1'b0, sb = 1'b0;
   logic       clk_a, clk_b, cfg_applied;

   dual_clock_postdiv uut (
      .clk_fast(clk), .rst_n(rst_n), .ratio_sel(sel), .half_b(hb),
      .stop_a(sa), .stop_b(sb), .clk_a(clk_a), .clk_b(clk_b),
      .cfg_applied(cfg_applied));

   always #10 clk = ~clk;

   int    tests = 0, fails = 0, cyc = 0;
   bit    started = 0, done = 0;
   string tag = "R4";

   // reference model state
   int t, R, hm, shR, shH;
   bit pa, pb, ra, rb, ea, eb, ef;

   function automatic int ratio_of(input logic [2:0] s);
      return (s >= 3'd6) ? 64 : (2 << s);
   endfunction

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000 && !done) begin
         tests++; fails++;
         $display("FAIL watchdog: actual=hung expected=finished");
         finish_run();
      end
      if (!rst_n) begin
         t = 0; R = ratio_of(sel); hm = hb; shR = R; shH = hb;
         pa = 0; pb = 0; ra = 1; rb = 1; ea = 0; eb = 0; ef = 0;
         started = 1;
      end else begin
         bit fin, na, nb;
         fin = (t == 2*R - 1);
         ef  = fin && (shR != R || shH != hm);
         if (fin) begin t = 0; R = shR; hm = shH; end
         else t = t + 1;
         shR = ratio_of(sel); shH = hb;
         na = (t % R) >= R/2;
         nb = hm ? (t >= R/2 && t < R + R/2) : na;
         ra = ra ? !(sa && !pa) : (!sa && na && !pa);
         rb = rb ? !(sb && !pb) : (!sb && nb && !pb);
         ea = ra && na; eb = rb && nb;
         pa = na; pb = nb;
      end
   end

   // pulse-length tracking (R6)
   int hla = 0, hlb = 0, xa = 0, xb = 0;

   always @(negedge clk) begin
      if (started && !done) begin
         tests++;
         if (clk_a !== ea || clk_b !== eb || cfg_applied !== cfg_applied_exp())
         begin
            fails++;
            $display("FAIL %s: a,b,flag actual=%b%b%b expected=%b%b%b",
                     tag, clk_a, clk_b, cfg_applied, ea, eb, ef);
         end
         if (clk_a === 1'b1) begin
            if (hla == 0) xa = R/2;
            hla++;
         end else if (hla != 0) begin
            tests++;
            if (hla != xa) begin
               fails++;
               $display("FAIL R6 pulse A: actual=%0d expected=%0d", hla, xa);
            end
            hla = 0;
         end
         if (clk_b === 1'b1) begin
            if (hlb == 0) xb = hm ? R : R/2;
            hlb++;
         end else if (hlb != 0) begin
            tests++;
            if (hlb != xb) begin
               fails++;
               $display("FAIL R6 pulse B: actual=%0d expected=%0d", hlb, xb);
            end
            hlb = 0;
         end
      end
   end

   function automatic bit cfg_applied_exp();
      return ef;
   endfunction

   task automatic wait_cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic set_cfg(input logic [2:0] s, input logic h, input int n);
      @(negedge clk); sel = s; hb = h;
      wait_cyc(n);
   endtask

   initial begin
      int n;
      // R4: reset state and first edge timing (ratio 16 -> 8 low cycles)
      tag = "R4";
      wait_cyc(3);
      tests++;
      if (clk_a !== 1'b0 || clk_b !== 1'b0 || cfg_applied !== 1'b0) begin
         fails++;
         $display("FAIL R4 reset: actual=%b%b%b expected=000", clk_a, clk_b, cfg_applied);
      end
      rst_n = 1'b1;
      n = 0;
      while (clk_a !== 1'b1 && n < 100) begin @(negedge clk); n++; end
      tests++;
      if (n != 8) begin
         fails++;
         $display("FAIL R4 first rise: actual=%0d expected=8", n);
      end
      // R1: every legal code, same-rate B
      tag = "R1";
      for (int c = 0; c < 6; c++) set_cfg(3'(c), 1'b0, 300);
      // R2: saturating codes, including a 5/6/7 sweep that must not flag
      tag = "R2";
      set_cfg(3'd6, 1'b0, 300);
      set_cfg(3'd7, 1'b0, 150);
      set_cfg(3'd5, 1'b0, 150);
      set_cfg(3'd7, 1'b1, 300);
      // R3: half-rate B for every code
      tag = "R3";
      for (int c = 0; c < 6; c++) set_cfg(3'(c), 1'b1, 300);
      // R5: changes at awkward offsets, including reverting before frame end
      tag = "R5";
      for (int i = 0; i < 40; i++) set_cfg(3'((i * 5) % 8), 1'(i % 2), (i * 7) % 23 + 1);
      set_cfg(3'd2, 1'b0, 200);
      set_cfg(3'd4, 1'b1, 3);
      set_cfg(3'd2, 1'b0, 200);
      // R7 and R8: stop A at every offset within a period of 8
      for (int k = 0; k < 8; k++) begin
         tag = "R7";
         wait_cyc(k);
         sa = 1'b1;
         wait_cyc(40);
         tag = "R8";
         sa = 1'b0;
         wait_cyc(40 + k);
      end
      // R9: stop B alone in half-rate mode, then both, then A alone
      tag = "R9";
      set_cfg(3'd1, 1'b1, 30);
      sb = 1'b1; wait_cyc(60);
      sa = 1'b1; wait_cyc(37);
      sb = 1'b0; wait_cyc(45);
      sa = 1'b0; wait_cyc(60);
      // R6: stops and ratio changes interleaved
      tag = "R6";
      for (int i = 0; i < 30; i++) begin
         @(negedge clk);
         sel = 3'((i * 3) % 6); hb = 1'(i % 3 == 0);
         sa = 1'(i % 4 == 1); sb = 1'(i % 5 == 2);
         wait_cyc((i * 11) % 37 + 5);
      end
      sa = 1'b0; sb = 1'b0;
      wait_cyc(300);
      finish_run();
   end
endmodule